// File: doc/BRIEF.md
# Regulator channel on/off sequencer

This block is the digital sequencer of one regulator output channel. It enables the power stage only when both the external run input and the software enable are high. It then steps through a turn-on wait, a rise phase, the on state, a turn-off wait and a fall phase. Phase lengths are programmed in milliseconds and counted on a millisecond tick input. The analog ramp is generated elsewhere. This block only decides when the stage is enabled and which phase is current.

During start-up it watches the undervoltage-OK comparator against an optional maximum rise time. In any powered phase it watches the overvoltage comparator. When either check fails, it applies the programmed response: latch off, or hold the run line low for the restart delay and then try again. On a normal turn-off it keeps the run line pulled low for a composite minimum time. Power-good is qualified by both comparators and is filtered only when it falls.

Top module: `rail_sequencer`

## Requirements
- R1: After reset, stageEn, runPullDown, powerGood, tonFault and ovFault are all 0.
- R2: When runIn and cmdOn are both high, the channel waits tOnDelay ticks and then raises stageEn one clock after the tick that completes the count. If either input drops during the wait, the channel returns to idle and the count restarts from zero.
- R3: The rise phase lasts tRise ticks and is then followed by the on state. powerGood is 0 during the rise phase. It goes to 1 one clock after the on state is reached, provided uvOk is 1 and ovFlag is 0.
- R4: The turn-on timeout counts ticks from the start of the rise phase, not from the on command. If uvOk has not been seen high by the time tOnMax ticks have elapsed, tonFault is set on the next clock.
- R5: A tOnMax value of 0 disables the timeout, so a channel whose uvOk never rises stays enabled indefinitely with tonFault at 0.
- R6: Dropping the enable in the on state keeps stageEn high for tOffDelay + tFall ticks. runPullDown goes high one clock after the off command and stays high until max(tOffDelay + tFall + FLOOR_MS, tRestart) ticks have elapsed since then.
- R7: ovFlag high in the rise, on, turn-off-wait or fall phase sets ovFault and applies the fault response on the next clock. ovFlag has no effect while the channel is idle.
- R8: When latchMode is 1, a fault clears stageEn on the next clock. The channel then stays off, even if the enable toggles, until a clearFaults pulse and a later rising edge of (runIn and cmdOn). clearFaults clears both fault flags.
- R9: When latchMode is 0, a fault clears stageEn and holds runPullDown high for exactly tRestart ticks, with no floor added. If the enable is still high, a new start follows.
- R10: While the channel is on, powerGood falls only after PG_FILTER consecutive bad clocks; a shorter bad pulse leaves it high. It rises again on the first good clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-clock strobe per millisecond |
| runIn | input | 1 | Run line level |
| cmdOn | input | 1 | Software on command |
| uvOk | input | 1 | Output above the undervoltage fault limit |
| ovFlag | input | 1 | Output above the overvoltage fault limit |
| clearFaults | input | 1 | Pulse that clears the fault flags and arms the exit from latch-off |
| latchMode | input | 1 | 1 = latch off on fault, 0 = retry |
| tOnDelay | input | TW | Turn-on wait, ticks |
| tRise | input | TW | Rise time, ticks |
| tOnMax | input | TW | Turn-on timeout, ticks (0 = none) |
| tOffDelay | input | TW | Turn-off wait, ticks |
| tFall | input | TW | Fall time, ticks |
| tRestart | input | TW | Restart delay / minimum run-low time, ticks |
| stageEn | output | 1 | Power-stage enable |
| runPullDown | output | 1 | Drives the run line low |
| powerGood | output | 1 | Filtered power-good |
| tonFault | output | 1 | Sticky turn-on timeout fault |
| ovFault | output | 1 | Sticky overvoltage fault |

## Verification
The on/off path is swept over a grid of turn-on wait and rise lengths. Each run checks the exact tick at which stageEn rises, powerGood rises, stageEn falls and runPullDown releases. This separates off-by-one counting from phase-order errors. Two run-low cases are used: one where the composite floor sets the hold time and one where the restart delay is larger, which shows that the maximum is taken. Timeout runs use a long turn-on wait, so a timer that starts at the on command would fault at once. A zero limit must never fault, and a retry run must release after the bare restart delay. Power-good is hit with a bad pulse one clock shorter than the filter and with one exactly as long, which pins down the filter length in the falling direction. The latch-off run toggles the enable before and after clearFaults, which shows that both the clear and a fresh on edge are needed to leave latch-off.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ON_DELAY,
    ST_RISE,
    ST_ON,
    ST_OFF_DELAY,
    ST_FALL,
    ST_RUN_HOLD,
    ST_LATCHED
  } seqState_t;

  // Strobes from control to the timer datapath
  typedef struct packed {
    logic phaseClr;  // restart the phase counter
    logic offClr;    // restart the run-low counter
    logic tonClr;    // restart the turn-on timeout counter
    logic pgWindow;  // channel is in the on state
  } seqStb_t;

endpackage

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
#(
  parameter int TW = 10,
  parameter int FLOOR_MS = 136
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          runIn,
  input  logic          cmdOn,
  input  logic          uvOk,
  input  logic          ovFlag,
  input  logic          clearFaults,
  input  logic          latchMode,
  input  logic [TW-1:0] tOnDelay,
  input  logic [TW-1:0] tRise,
  input  logic [TW-1:0] tOnMax,
  input  logic [TW-1:0] tOffDelay,
  input  logic [TW-1:0] tFall,
  input  logic [TW-1:0] tRestart,
  input  logic [TW+1:0] phaseCnt,
  input  logic [TW+1:0] offCnt,
  input  logic [TW+1:0] tonCnt,
  input  logic          uvReached,
  output seqStb_t       stb,
  output logic          stageEn,
  output logic          runPullDown,
  output logic          tonFault,
  output logic          ovFault
);

  localparam int CW = TW + 2;
  localparam logic [CW-1:0] FLOOR = CW'(FLOOR_MS);

  seqState_t state, nextState;
  logic retryHold, armed, onPrev;
  logic chanOn, onRise, active, tonExpired, faultHit;
  logic [CW-1:0] normTgt, holdTgt;

  function automatic logic [CW-1:0] ext(input logic [TW-1:0] v);
    return {2'b00, v};
  endfunction

  always_comb begin
    chanOn     = runIn & cmdOn;
    onRise     = chanOn & ~onPrev;
    active     = (state == ST_RISE) || (state == ST_ON) ||
                 (state == ST_OFF_DELAY) || (state == ST_FALL);
    tonExpired = ((state == ST_RISE) || (state == ST_ON)) && (tOnMax != '0) &&
                 !uvOk && !uvReached && (tonCnt >= ext(tOnMax));
    faultHit   = (active && ovFlag) || tonExpired;
    normTgt    = ext(tOffDelay) + ext(tFall) + FLOOR;
    if (retryHold) holdTgt = ext(tRestart);
    else           holdTgt = (normTgt > ext(tRestart)) ? normTgt : ext(tRestart);
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:      if (chanOn) nextState = ST_ON_DELAY;
      ST_ON_DELAY:  if (!chanOn) nextState = ST_IDLE;
                    else if (phaseCnt >= ext(tOnDelay)) nextState = ST_RISE;
      ST_RISE:      if (phaseCnt >= ext(tRise)) nextState = ST_ON;
      ST_ON:        if (!chanOn) nextState = ST_OFF_DELAY;
      ST_OFF_DELAY: if (phaseCnt >= ext(tOffDelay)) nextState = ST_FALL;
      ST_FALL:      if (phaseCnt >= ext(tFall)) nextState = ST_RUN_HOLD;
      ST_RUN_HOLD:  if (offCnt >= holdTgt) nextState = ST_IDLE;
      ST_LATCHED:   if (armed && onRise) nextState = ST_ON_DELAY;
      default:      nextState = ST_IDLE;
    endcase
    if (faultHit) nextState = latchMode ? ST_LATCHED : ST_RUN_HOLD;
  end

  always_comb begin
    stb.phaseClr = (nextState != state);
    stb.offClr   = ((state == ST_ON) && (nextState == ST_OFF_DELAY)) ||
                   (faultHit && !latchMode);
    stb.tonClr   = (nextState == ST_RISE) && (state != ST_RISE);
    stb.pgWindow = (state == ST_ON);
    stageEn      = active;
    runPullDown  = (state == ST_OFF_DELAY) || (state == ST_FALL) ||
                   (state == ST_RUN_HOLD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      retryHold <= 1'b0;
      armed     <= 1'b0;
      onPrev    <= 1'b0;
      tonFault  <= 1'b0;
      ovFault   <= 1'b0;
    end else begin
      state  <= nextState;
      onPrev <= chanOn;
      if (faultHit && !latchMode) retryHold <= 1'b1;
      else if (nextState == ST_OFF_DELAY) retryHold <= 1'b0;
      if (state != ST_LATCHED) armed <= 1'b0;
      else if (clearFaults)    armed <= 1'b1;
      tonFault <= tonExpired | (tonFault & ~clearFaults);
      ovFault  <= (active & ovFlag) | (ovFault & ~clearFaults);
    end
  end

  // R8
  latch_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultHit && latchMode) |=> (state == ST_LATCHED) && !stageEn);

  // R7
  ov_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && ovFlag) |=> ovFault && ((state == ST_LATCHED) || (state == ST_RUN_HOLD)));

  // R6
  hold_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(runPullDown) && (state == ST_IDLE) && !$past(retryHold))
      |-> ($past(offCnt) >= $past(normTgt)));

  // R4
  ton_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tonFault) |-> (($past(tOnMax) != '0) && ($past(tonCnt) >= ext($past(tOnMax)))));

endmodule

// File: rtl/rail_seq_timers.sv
module rail_seq_timers
  import rail_seq_pkg::*;
#(
  parameter int CW = 12,
  parameter int PG_FILTER = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          msTick,
  input  logic          uvOk,
  input  logic          ovFlag,
  input  seqStb_t       stb,
  output logic [CW-1:0] phaseCnt,
  output logic [CW-1:0] offCnt,
  output logic [CW-1:0] tonCnt,
  output logic          uvReached,
  output logic          powerGood
);

  localparam int NCNT = 3;
  localparam int FW = $clog2(PG_FILTER + 1);

  logic [NCNT-1:0]         clrVec;
  logic [NCNT-1:0][CW-1:0] cntVec;
  logic [FW-1:0]           pgCnt;
  logic                    pgGood;

  assign clrVec   = {stb.tonClr, stb.offClr, stb.phaseClr};
  assign phaseCnt = cntVec[0];
  assign offCnt   = cntVec[1];
  assign tonCnt   = cntVec[2];
  assign pgGood   = uvOk & ~ovFlag;

  // Saturating millisecond counters, one per timer
  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN || clrVec[i])                 cntVec[i] <= '0;
      else if (msTick && (cntVec[i] != '1))   cntVec[i] <= cntVec[i] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.tonClr) uvReached <= 1'b0;
    else if (uvOk)           uvReached <= 1'b1;
  end

  // Power-good: immediate rise, filtered fall
  always_ff @(posedge clk) begin
    if (!rstN || !stb.pgWindow) begin
      powerGood <= 1'b0;
      pgCnt     <= '0;
    end else if (pgGood) begin
      powerGood <= 1'b1;
      pgCnt     <= '0;
    end else if (powerGood) begin
      if (pgCnt == FW'(PG_FILTER - 1)) begin
        powerGood <= 1'b0;
        pgCnt     <= '0;
      end else begin
        pgCnt <= pgCnt + 1'b1;
      end
    end
  end

  // R3
  pg_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerGood |-> $past(stb.pgWindow));

  // R10
  pg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(powerGood) && stb.pgWindow && $past(stb.pgWindow) && $past(pgCnt) != FW'(PG_FILTER - 1))
      |-> powerGood);

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rail_seq_pkg::*;
#(
  parameter int TW = 10,
  parameter int FLOOR_MS = 136,
  parameter int PG_FILTER = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          msTick,
  input  logic          runIn,
  input  logic          cmdOn,
  input  logic          uvOk,
  input  logic          ovFlag,
  input  logic          clearFaults,
  input  logic          latchMode,
  input  logic [TW-1:0] tOnDelay,
  input  logic [TW-1:0] tRise,
  input  logic [TW-1:0] tOnMax,
  input  logic [TW-1:0] tOffDelay,
  input  logic [TW-1:0] tFall,
  input  logic [TW-1:0] tRestart,
  output logic          stageEn,
  output logic          runPullDown,
  output logic          powerGood,
  output logic          tonFault,
  output logic          ovFault
);

  localparam int CW = TW + 2;

  seqStb_t       stb;
  logic [CW-1:0] phaseCnt, offCnt, tonCnt;
  logic          uvReached;

  rail_seq_ctrl #(.TW(TW), .FLOOR_MS(FLOOR_MS)) u_ctrl (
    .clk(clk), .rstN(rstN), .runIn(runIn), .cmdOn(cmdOn), .uvOk(uvOk),
    .ovFlag(ovFlag), .clearFaults(clearFaults), .latchMode(latchMode),
    .tOnDelay(tOnDelay), .tRise(tRise), .tOnMax(tOnMax),
    .tOffDelay(tOffDelay), .tFall(tFall), .tRestart(tRestart),
    .phaseCnt(phaseCnt), .offCnt(offCnt), .tonCnt(tonCnt),
    .uvReached(uvReached), .stb(stb), .stageEn(stageEn),
    .runPullDown(runPullDown), .tonFault(tonFault), .ovFault(ovFault)
  );

  rail_seq_timers #(.CW(CW), .PG_FILTER(PG_FILTER)) u_timers (
    .clk(clk), .rstN(rstN), .msTick(msTick), .uvOk(uvOk), .ovFlag(ovFlag),
    .stb(stb), .phaseCnt(phaseCnt), .offCnt(offCnt), .tonCnt(tonCnt),
    .uvReached(uvReached), .powerGood(powerGood)
  );

endmodule

// File: tb/rail_sequencer_bench.sv
`timescale 1ns/1ps
module rail_sequencer_bench;

  localparam int TW = 10;
  localparam int FLOOR = 136;
  localparam int PGF = 6;

  logic clk = 1'b0;
  logic rstN, msTick, runIn, cmdOn, uvOk, ovFlag, clearFaults, latchMode;
  logic [TW-1:0] tOnDelay, tRise, tOnMax, tOffDelay, tFall, tRestart;
  logic stageEn, runPullDown, powerGood, tonFault, ovFault;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rail_sequencer #(.TW(TW), .FLOOR_MS(FLOOR), .PG_FILTER(PGF)) u_rail_sequencer (
    .clk(clk), .rstN(rstN), .msTick(msTick), .runIn(runIn), .cmdOn(cmdOn),
    .uvOk(uvOk), .ovFlag(ovFlag), .clearFaults(clearFaults), .latchMode(latchMode),
    .tOnDelay(tOnDelay), .tRise(tRise), .tOnMax(tOnMax), .tOffDelay(tOffDelay),
    .tFall(tFall), .tRestart(tRestart), .stageEn(stageEn), .runPullDown(runPullDown),
    .powerGood(powerGood), .tonFault(tonFault), .ovFault(ovFault)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      msTick = 1'b1;
      cyc(1);
      msTick = 1'b0;
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; msTick = 1'b0; runIn = 1'b1; cmdOn = 1'b0; uvOk = 1'b1;
    ovFlag = 1'b0; clearFaults = 1'b0; latchMode = 1'b1;
    tOnDelay = 1; tRise = 1; tOnMax = 0; tOffDelay = 1; tFall = 1; tRestart = 5;
    cyc(2);
    rstN = 1'b1;
    cyc(1);
  endtask

  // Full on/off cycle with exact tick placement
  task automatic runSeq(input int d, input int r, input int od, input int fl, input int rs);
    int h;
    tOnDelay = TW'(d); tRise = TW'(r); tOffDelay = TW'(od); tFall = TW'(fl);
    tRestart = TW'(rs);
    h = (od + fl + FLOOR > rs) ? od + fl + FLOOR : rs;
    cmdOn = 1'b1; cyc(1);
    ticks(d - 1);
    check("R2 stage off during on-wait", stageEn, 0);
    ticks(1); cyc(1);
    check("R2 stage on after on-wait", stageEn, 1);
    ticks(r - 1);
    check("R3 no power-good in rise", powerGood, 0);
    ticks(1); cyc(1);
    check("R3 power-good one clock after on", powerGood, 0);
    cyc(1);
    check("R3 power-good in on", powerGood, 1);
    cmdOn = 1'b0; cyc(1);
    check("R6 pulldown after off command", runPullDown, 1);
    check("R6 stage held in off-wait", stageEn, 1);
    ticks(od); cyc(1);
    ticks(fl - 1);
    check("R6 stage held in fall", stageEn, 1);
    ticks(1); cyc(1);
    check("R6 stage off after fall", stageEn, 0);
    ticks(h - (od + fl) - 1);
    check("R6 pulldown still held", runPullDown, 1);
    ticks(1); cyc(1);
    check("R6 pulldown released", runPullDown, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    check("R1 stageEn reset", stageEn, 0);
    check("R1 runPullDown reset", runPullDown, 0);
    check("R1 powerGood reset", powerGood, 0);
    check("R1 tonFault reset", tonFault, 0);
    check("R1 ovFault reset", ovFault, 0);

    // R2 R3 R6: sweep of wait and rise lengths, floor-dominated hold
    for (int d = 1; d <= 3; d++)
      for (int r = 1; r <= 3; r++) begin
        doReset();
        runSeq(d, r, 2, 3, 5);
      end
    // R6: restart delay dominates the hold
    doReset();
    runSeq(1, 1, 1, 1, 200);

    // R2: enable drop during the wait restarts the count
    doReset();
    tOnDelay = 5;
    cmdOn = 1'b1; cyc(1);
    ticks(2);
    runIn = 1'b0; cyc(1);
    runIn = 1'b1; cyc(1);
    ticks(4);
    check("R2 count restarted after drop", stageEn, 0);
    ticks(1); cyc(1);
    check("R2 start after full wait", stageEn, 1);

    // R7: overvoltage ignored while idle
    doReset();
    ovFlag = 1'b1; cyc(4);
    check("R7 ov ignored in idle", ovFault, 0);
    ovFlag = 1'b0;

    // R4 R8: timeout from rise start, latch-off and exit rules
    doReset();
    tOnDelay = 6; tRise = 20; tOnMax = 4; uvOk = 1'b0;
    cmdOn = 1'b1; cyc(1);
    ticks(6); cyc(1);
    check("R4 no fault at rise start", tonFault, 0);
    check("R4 rising", stageEn, 1);
    ticks(3);
    check("R4 no fault before limit", tonFault, 0);
    ticks(1); cyc(1);
    check("R4 timeout fault", tonFault, 1);
    check("R8 stage off on latch", stageEn, 0);
    cmdOn = 1'b0; cyc(2); cmdOn = 1'b1; cyc(3);
    check("R8 toggle without clear stays off", stageEn, 0);
    clearFaults = 1'b1; cyc(1); clearFaults = 1'b0;
    check("R8 clear resets flag", tonFault, 0);
    cyc(3);
    check("R8 clear alone stays off", stageEn, 0);
    tOnDelay = 1;
    cmdOn = 1'b0; cyc(1); cmdOn = 1'b1; cyc(1);
    ticks(1); cyc(1);
    check("R8 restart after clear and new on", stageEn, 1);

    // R5: zero limit never times out
    doReset();
    tOnMax = 0; uvOk = 1'b0; tOnDelay = 1; tRise = 2;
    cmdOn = 1'b1; cyc(1);
    ticks(1); cyc(1);
    ticks(2); cyc(1);
    ticks(60);
    check("R5 no timeout with zero limit", tonFault, 0);
    check("R5 stage stays on", stageEn, 1);
    check("R5 no power-good without uv", powerGood, 0);

    // R9: retry holds the run line for the bare restart delay
    doReset();
    latchMode = 1'b0; tRestart = 5; tOnDelay = 1; tRise = 20; tOnMax = 3; uvOk = 1'b0;
    cmdOn = 1'b1; cyc(1);
    ticks(1); cyc(1);
    ticks(2);
    ticks(1); cyc(1);
    check("R9 fault flag", tonFault, 1);
    check("R9 stage off", stageEn, 0);
    check("R9 pulldown on", runPullDown, 1);
    ticks(4);
    check("R9 pulldown held", runPullDown, 1);
    ticks(1); cyc(1);
    check("R9 pulldown released after restart delay", runPullDown, 0);
    cyc(1);
    ticks(1); cyc(1);
    check("R9 retry start", stageEn, 1);

    // R7: overvoltage in on state with latch response
    doReset();
    cmdOn = 1'b1; cyc(1);
    ticks(1); cyc(1); ticks(1); cyc(2);
    check("R7 on before ov", powerGood, 1);
    ovFlag = 1'b1; cyc(1);
    check("R7 ov flag", ovFault, 1);
    check("R7 stage off on ov", stageEn, 0);
    ovFlag = 1'b0;

    // R10: power-good fall filter
    doReset();
    cmdOn = 1'b1; cyc(1);
    ticks(1); cyc(1); ticks(1); cyc(2);
    check("R10 good before glitch", powerGood, 1);
    uvOk = 1'b0; cyc(PGF - 1);
    check("R10 short bad pulse filtered", powerGood, 1);
    uvOk = 1'b1; cyc(1);
    uvOk = 1'b0; cyc(PGF - 1);
    check("R10 still good one clock short", powerGood, 1);
    cyc(1);
    check("R10 drops after full filter", powerGood, 0);
    uvOk = 1'b1; cyc(1);
    check("R10 immediate rise", powerGood, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule